// File: doc/BRIEF.md
# LCD Serial Command/Data Transmitter

This block is a transmit-only synchronous serial master that feeds words to a display controller. A host hands it one word at a time, 8, 16, 18 or 24 bits wide, each tagged as a command or as data. The block serialises the word MSB first on a clock it derives from the system clock. It frames the transfer with an active-low chip select and supports all four combinations of clock polarity and phase.

The command/data tag travels in one of two ways, chosen by configuration. In in-band mode it is an extra first bit of the serial frame. In separate-pin mode it is driven on a dedicated A0 output, which is set before chip select falls and held until it rises. For 18-bit words a format field selects one of four bit arrangements. The host side is a one-word buffer with a valid/ready handshake. A level interrupt and a DMA request both report that the buffer is empty. When the buffer is refilled before the current word finishes, the next word follows with no gap and chip select stays low.

The controller has five states. IDLE waits for a buffered word. IDLE→LEAD takes the word and sets A0 while chip select is still high. LEAD→SETUP drops chip select. SETUP→SHIFT follows after one half clock period. SHIFT clocks the bits out. SHIFT→SHIFT reloads the next word at the last trailing edge (chaining). SHIFT→HOLD is taken when no word can be chained. HOLD→IDLE raises chip select after one half period.

Top module: `lcd_ser_tx`

## Requirements
- R1: After reset lcd_cs_n is 1, lcd_sclk equals cfg_cpol, lcd_a0 is 0, and tx_ready, irq_tx_empty and dma_req are 1.
- R2: cfg_len selects the word length: 0 gives 8 bits, 1 gives 16, 2 gives 18 and 3 gives 24. The low bits of tx_word are sent, most significant bit first.
- R3: With cfg_len=2, cfg_fmt18 orders the 18 bits. 0 sends tx_word[17:0] as is. 1 sends {[5:0],[11:6],[17:12]}. 2 sends {[11:6],[17:12],[5:0]}. 3 sends the 18 bits reversed, with bit 0 first. In every case the leftmost bit goes first.
- R4: With cfg_sep_a0=0, each frame starts with one tag bit, 0 for a command (tx_is_cmd=1) and 1 for data, followed by the word. The frame is length+1 clocks long, and lcd_a0 is 0 throughout.
- R5: With cfg_sep_a0=1, the frame is length clocks long. lcd_a0 carries the tag (0 command, 1 data). It takes its value at least one system clock before lcd_cs_n falls and is stable while lcd_cs_n is low.
- R6: lcd_sclk rests at cfg_cpol while lcd_cs_n is high. With cfg_cpha=0, lcd_mosi is valid before the first edge and the receiver samples on leading edges (away from cfg_cpol). With cfg_cpha=1, the receiver samples on trailing edges.
- R7: Each lcd_sclk half period lasts cfg_half+1 system clocks, so the divide ratio is 2*(cfg_half+1) with a minimum of 2. Consecutive sampling edges are 2*(cfg_half+1) clocks apart, including across chained words.
- R8: If the next word is buffered before the last trailing edge of the current word, it follows at once and lcd_cs_n stays low. In separate-pin mode this holds only if its tag equals the current one. Otherwise lcd_cs_n rises before the next word.
- R9: The buffer holds one word. tx_ready, irq_tx_empty and dma_req are 1 exactly when it is empty. They drop in the cycle after a word is accepted and return once the controller takes the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 2 | Word length code |
| cfg_fmt18 | input | 2 | 18-bit arrangement code |
| cfg_sep_a0 | input | 1 | 1: tag on lcd_a0, 0: tag as leading bit |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Serial clock sampling phase |
| cfg_half | input | DIV_W | Half period minus one, in system clocks |
| tx_valid | input | 1 | Host offers a word |
| tx_ready | output | 1 | Buffer can accept a word |
| tx_word | input | 24 | Word to send |
| tx_is_cmd | input | 1 | 1: command, 0: data |
| irq_tx_empty | output | 1 | Transmit-empty interrupt level |
| dma_req | output | 1 | DMA request, mirrors empty |
| lcd_sclk | output | 1 | Serial clock |
| lcd_mosi | output | 1 | Serial data |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_a0 | output | 1 | Command/data pin |

## Verification
Two functions can coincide at the last trailing edge of a word: the chaining reload and the A0 integrity rule in separate-pin mode. The bench provokes this by queueing a command right behind data words while the first word is still shifting. The buffer is therefore full with a different tag at that edge. It judges the result by counting chip-select rises, which must be two for three words, against one rise when the same sequence is sent in in-band mode. It also checks that every bit was sampled with the expected A0 level and that the sampling-edge spacing never broke inside a chain.

// File: rtl/lcd_ser_pkg.sv
package lcd_ser_pkg;
    localparam int WORD_W  = 24;
    localparam int FRAME_W = WORD_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        LEN_8  = 2'd0,
        LEN_16 = 2'd1,
        LEN_18 = 2'd2,
        LEN_24 = 2'd3
    } wlen_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD
    } ser_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;   // first bit at the top
        logic [CNT_W-1:0]   nbits;
        logic               dc;     // 0 command, 1 data
    } frame_t;
endpackage

// File: rtl/lcd_tx_buf.sv
module lcd_tx_buf
    import lcd_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    output logic              push_ready,
    input  logic [WORD_W-1:0] push_data,
    input  logic              push_cmd,
    input  logic              pop,
    output logic              full,
    output logic [WORD_W-1:0] q_data,
    output logic              q_cmd
);
    logic full_q;

    assign push_ready = !full_q;
    assign full       = full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            q_data <= '0;
            q_cmd  <= 1'b0;
        end else if (push_valid && !full_q) begin
            full_q <= 1'b1;
            q_data <= push_data;
            q_cmd  <= push_cmd;
        end else if (pop) begin
            full_q <= 1'b0;
        end
    end

    // R9: an accepted word closes the buffer on the next cycle
    p_accept_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready) |=> !push_ready);
    // R9: a full buffer stays full until the controller takes it
    p_hold_until_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);
endmodule

// File: rtl/lcd_word_fmt.sv
module lcd_word_fmt
    import lcd_ser_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              is_cmd,
    input  wlen_e             len,
    input  logic [1:0]        fmt18,
    input  logic              sep,
    output frame_t            frame
);
    localparam int GRP = 6;

    logic [17:0]       rev18;
    logic [17:0]       w18;
    logic [WORD_W-1:0] payload;
    logic [CNT_W-1:0]  base;
    logic              dc;

    for (genvar i = 0; i < 18; i++) begin : g_rev
        assign rev18[i] = word[17-i];
    end

    assign dc = !is_cmd;

    always_comb begin
        unique case (fmt18)
            2'd0: w18 = word[17:0];
            2'd1: w18 = {word[GRP-1:0], word[2*GRP-1:GRP], word[3*GRP-1:2*GRP]};
            2'd2: w18 = {word[2*GRP-1:GRP], word[3*GRP-1:2*GRP], word[GRP-1:0]};
            default: w18 = rev18;
        endcase
    end

    always_comb begin
        unique case (len)
            LEN_8: begin
                payload = {word[7:0], 16'b0};
                base    = CNT_W'(8);
            end
            LEN_16: begin
                payload = {word[15:0], 8'b0};
                base    = CNT_W'(16);
            end
            LEN_18: begin
                payload = {w18, 6'b0};
                base    = CNT_W'(18);
            end
            default: begin
                payload = word;
                base    = CNT_W'(24);
            end
        endcase
    end

    always_comb begin
        frame.dc = dc;
        if (sep) begin
            frame.bits  = {payload, 1'b0};
            frame.nbits = base;
        end else begin
            frame.bits  = {dc, payload};
            frame.nbits = base + CNT_W'(1);
        end
    end
endmodule

// File: rtl/lcd_clk_div.sv
module lcd_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == half);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (!run || tick)  cnt <= '0;
        else                    cnt <= cnt + DIV_W'(1);
    end

    // R7: the half-period counter never passes its limit
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= half));
endmodule

// File: rtl/lcd_ser_fsm.sv
module lcd_ser_fsm
    import lcd_ser_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cfg_cpol,
    input  logic   cfg_cpha,
    input  logic   cfg_sep,
    input  logic   buf_full,
    input  frame_t nxt,
    input  logic   tick,
    output logic   buf_pop,
    output logic   run,
    output logic   sclk,
    output logic   mosi,
    output logic   cs_n,
    output logic   a0
);
    ser_state_e         state, state_nx;
    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   nbits_q;
    logic [CNT_W-1:0]   bitcnt;
    logic               dc_q;
    logic               ph;
    logic               mosi_q;
    logic               a0_q;
    logic               last_edge;
    logic               chain;

    assign chain     = buf_full && (!cfg_sep || (nxt.dc == dc_q));
    assign last_edge = (state == ST_SHIFT) && tick && ph
                       && (bitcnt == nbits_q - CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (buf_full) state_nx = ST_LEAD;
            ST_LEAD:  state_nx = ST_SETUP;
            ST_SETUP: if (tick) state_nx = ST_SHIFT;
            ST_SHIFT: if (last_edge) state_nx = chain ? ST_SHIFT : ST_HOLD;
            ST_HOLD:  if (tick) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    assign buf_pop = ((state == ST_IDLE) && buf_full) || (last_edge && chain);

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr      <= '0;
            nbits_q <= '0;
            bitcnt  <= '0;
            dc_q    <= 1'b0;
            ph      <= 1'b0;
            mosi_q  <= 1'b0;
            a0_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (buf_full) begin
                    sr      <= nxt.bits;
                    nbits_q <= nxt.nbits;
                    dc_q    <= nxt.dc;
                    a0_q    <= cfg_sep & nxt.dc;
                    bitcnt  <= '0;
                    ph      <= 1'b0;
                end
                ST_LEAD: if (!cfg_cpha) begin
                    mosi_q <= sr[FRAME_W-1];
                    sr     <= {sr[FRAME_W-2:0], 1'b0};
                end
                ST_SHIFT: if (tick) begin
                    if (!ph) begin
                        ph <= 1'b1;
                        if (cfg_cpha) begin
                            mosi_q <= sr[FRAME_W-1];
                            sr     <= {sr[FRAME_W-2:0], 1'b0};
                        end
                    end else begin
                        ph <= 1'b0;
                        if (last_edge) begin
                            if (chain) begin
                                nbits_q <= nxt.nbits;
                                dc_q    <= nxt.dc;
                                bitcnt  <= '0;
                                if (!cfg_cpha) begin
                                    mosi_q <= nxt.bits[FRAME_W-1];
                                    sr     <= {nxt.bits[FRAME_W-2:0], 1'b0};
                                end else begin
                                    sr <= nxt.bits;
                                end
                            end
                        end else begin
                            bitcnt <= bitcnt + CNT_W'(1);
                            if (!cfg_cpha) begin
                                mosi_q <= sr[FRAME_W-1];
                                sr     <= {sr[FRAME_W-2:0], 1'b0};
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cs_n = (state == ST_IDLE) || (state == ST_LEAD);
        run  = (state == ST_SETUP) || (state == ST_SHIFT) || (state == ST_HOLD);
        sclk = cfg_cpol ^ ph;
        mosi = mosi_q;
        a0   = a0_q;
    end

    // R5: A0 settles before chip select falls
    p_a0_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $stable(a0));
    // R5: A0 does not move while chip select is low
    p_a0_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(a0));
    // R4: in-band mode keeps A0 low during a frame
    p_inband_a0_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_sep && !cs_n) |-> !a0);
    // R6: clock rests at its idle level outside a frame
    p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sclk == cfg_cpol));
    // R7: the serial clock only moves on a divider tick
    p_edge_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(ph));
endmodule

// File: rtl/lcd_ser_tx.sv
module lcd_ser_tx
    import lcd_ser_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_fmt18,
    input  logic              cfg_sep_a0,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DIV_W-1:0]  cfg_half,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_is_cmd,
    output logic              irq_tx_empty,
    output logic              dma_req,
    output logic              lcd_sclk,
    output logic              lcd_mosi,
    output logic              lcd_cs_n,
    output logic              lcd_a0
);
    logic              buf_full;
    logic              buf_pop;
    logic [WORD_W-1:0] buf_data;
    logic              buf_cmd;
    frame_t            nxt;
    logic              run;
    logic              tick;

    lcd_tx_buf u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (tx_valid),
        .push_ready (tx_ready),
        .push_data  (tx_word),
        .push_cmd   (tx_is_cmd),
        .pop        (buf_pop),
        .full       (buf_full),
        .q_data     (buf_data),
        .q_cmd      (buf_cmd)
    );

    lcd_word_fmt u_fmt (
        .word   (buf_data),
        .is_cmd (buf_cmd),
        .len    (wlen_e'(cfg_len)),
        .fmt18  (cfg_fmt18),
        .sep    (cfg_sep_a0),
        .frame  (nxt)
    );

    lcd_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .half  (cfg_half),
        .tick  (tick)
    );

    lcd_ser_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_cpol (cfg_cpol),
        .cfg_cpha (cfg_cpha),
        .cfg_sep  (cfg_sep_a0),
        .buf_full (buf_full),
        .nxt      (nxt),
        .tick     (tick),
        .buf_pop  (buf_pop),
        .run      (run),
        .sclk     (lcd_sclk),
        .mosi     (lcd_mosi),
        .cs_n     (lcd_cs_n),
        .a0       (lcd_a0)
    );

    assign irq_tx_empty = !buf_full;
    assign dma_req      = !buf_full;
endmodule

// File: tb/lcd_ser_tx_bench.sv
module lcd_ser_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_len = 2'd0;
    logic [1:0]  cfg_fmt18 = 2'd0;
    logic        cfg_sep_a0 = 1'b0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic [7:0]  cfg_half = 8'd1;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [23:0] tx_word = '0;
    logic        tx_is_cmd = 1'b0;
    logic        irq_tx_empty, dma_req, lcd_sclk, lcd_mosi, lcd_cs_n, lcd_a0;

    always #10 clk = ~clk;   // 50 MHz

    lcd_ser_tx u_lcd_ser_tx (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_fmt18(cfg_fmt18),
        .cfg_sep_a0(cfg_sep_a0), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_half(cfg_half), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_word(tx_word), .tx_is_cmd(tx_is_cmd), .irq_tx_empty(irq_tx_empty),
        .dma_req(dma_req), .lcd_sclk(lcd_sclk), .lcd_mosi(lcd_mosi),
        .lcd_cs_n(lcd_cs_n), .lcd_a0(lcd_a0)
    );

    typedef struct packed {
        logic [31:0] seq;   // seq[i] = i-th bit on the wire
        logic [7:0]  n;
        logic        a0;
    } item_t;

    item_t q[$];
    int vectors = 0;
    int miscompares = 0;
    int cs_rises = 0;
    int cyc = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // expected wire order, from R2/R3/R4/R5
    function automatic item_t model(input logic [23:0] w, input logic cmd);
        item_t it;
        int L, k, g, p, sg, src;
        logic dc;
        dc = !cmd;
        L = (cfg_len == 2'd0) ? 8 : (cfg_len == 2'd1) ? 16 : (cfg_len == 2'd2) ? 18 : 24;
        it.seq = '0;
        k = 0;
        if (!cfg_sep_a0) begin
            it.seq[0] = dc;
            k = 1;
        end
        for (int i = 0; i < L; i++) begin
            if (cfg_len != 2'd2) src = L - 1 - i;
            else begin
                g = i / 6; p = i % 6;
                case (cfg_fmt18)
                    2'd0: src = 17 - i;
                    2'd1: src = g * 6 + 5 - p;
                    2'd2: begin sg = (g == 0) ? 1 : (g == 1) ? 2 : 0; src = sg * 6 + 5 - p; end
                    default: src = i;
                endcase
            end
            it.seq[k + i] = w[src];
        end
        it.n  = 8'(L + k);
        it.a0 = cfg_sep_a0 ? dc : 1'b0;
        return it;
    endfunction

    task automatic send(input logic [23:0] w, input logic cmd, input bit chk_hs);
        q.push_back(model(w, cmd));
        @(negedge clk);
        tx_word = w; tx_is_cmd = cmd; tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        if (chk_hs) begin
            chk("R9 ready low after accept", {31'b0, tx_ready}, 32'd0);
            chk("R9 irq low after accept", {31'b0, irq_tx_empty}, 32'd0);
            chk("R9 dma low after accept", {31'b0, dma_req}, 32'd0);
            @(negedge clk);
            chk("R9 ready back once taken", {31'b0, tx_ready}, 32'd1);
            chk("R9 irq back once taken", {31'b0, irq_tx_empty}, 32'd1);
        end
    endtask

    task automatic wait_idle();
        while (q.size() != 0 || !lcd_cs_n || !tx_ready) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // monitor: samples on the receiver's edge, away from the system clock edge
    logic [31:0] got;
    int  cnt = 0;
    bit  have_prev = 0;
    int  last_cyc = 0;
    bit  a0_bad = 0, sp_bad = 0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_cs && !lcd_cs_n) begin
                if (q.size() == 0) chk("R8 unexpected frame start", 32'd1, 32'd0);
                else chk("R5 a0 before cs falls", {31'b0, lcd_a0}, {31'b0, q[0].a0});
            end
            if (!prev_cs && lcd_cs_n) begin
                cs_rises++;
                if (cnt != 0) chk("R8 frame cut by cs", cnt, 32'd0);
                cnt = 0;
            end
            if (lcd_cs_n) have_prev = 0;
            if (!lcd_cs_n && (lcd_sclk != prev_sclk)
                && ((lcd_sclk != cfg_cpol) == (cfg_cpha == 1'b0))) begin
                if (q.size() == 0) chk("R2 extra bit", 32'd1, 32'd0);
                else begin
                    if (cnt == 0) begin got = '0; a0_bad = 0; sp_bad = 0; end
                    if (lcd_a0 !== q[0].a0) a0_bad = 1;
                    if (have_prev && (cyc - last_cyc) != 2 * (int'(cfg_half) + 1)) sp_bad = 1;
                    have_prev = 1; last_cyc = cyc;
                    got[cnt] = lcd_mosi;
                    cnt++;
                    if (cnt == int'(q[0].n)) begin
                        chk($sformatf("R2/R3/R4/R6 frame len=%0d fmt=%0d sep=%0d mode=%0d%0d",
                            cfg_len, cfg_fmt18, cfg_sep_a0, cfg_cpol, cfg_cpha), got, q[0].seq);
                        chk(cfg_sep_a0 ? "R5 a0 during frame" : "R4 a0 low in-band",
                            {31'b0, a0_bad}, 32'd0);
                        chk("R7 sampling edge spacing", {31'b0, sp_bad}, 32'd0);
                        void'(q.pop_front());
                        cnt = 0;
                    end
                end
            end
        end
        prev_sclk = lcd_sclk;
        prev_cs = lcd_cs_n;
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog R8 act=running exp=idle");
        finish_run();
    end

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", {31'b0, lcd_cs_n}, 32'd1);
        chk("R1 sclk idle", {31'b0, lcd_sclk}, {31'b0, cfg_cpol});
        chk("R1 a0", {31'b0, lcd_a0}, 32'd0);
        chk("R1 ready", {31'b0, tx_ready}, 32'd1);
        chk("R1 irq", {31'b0, irq_tx_empty}, 32'd1);
        chk("R1 dma", {31'b0, dma_req}, 32'd1);

        // R9 handshake from idle
        send(24'h0000A5, 1'b0, 1'b1);
        wait_idle();

        // R6: all four clock modes, 8-bit in-band words
        for (int m = 0; m < 4; m++) begin
            cfg_cpol = m[1]; cfg_cpha = m[0];
            @(negedge clk);
            chk("R6 idle level follows polarity", {31'b0, lcd_sclk}, {31'b0, cfg_cpol});
            send(24'h00003C ^ 24'(m * 17), 1'b1, 1'b0);
            send(24'h0000C3, 1'b0, 1'b0);
            wait_idle();
        end

        // R2/R7: 16 and 24 bits, divide by 2, separate pin
        cfg_half = 8'd0; cfg_sep_a0 = 1'b1; cfg_cpol = 1'b0; cfg_cpha = 1'b1;
        cfg_len = 2'd1; send(24'h00BEEF, 1'b0, 1'b0); wait_idle();
        cfg_len = 2'd3; send(24'hA1B2C3, 1'b1, 1'b0); wait_idle();
        cfg_half = 8'd3; cfg_cpha = 1'b0;
        send(24'h5A5A0F, 1'b0, 1'b0); wait_idle();

        // R3: the four 18-bit arrangements
        cfg_len = 2'd2; cfg_half = 8'd2; cfg_sep_a0 = 1'b0;
        for (int f = 0; f < 4; f++) begin
            cfg_fmt18 = f[1:0];
            send(24'h02D1E7, 1'b0, 1'b0);
            send(24'h01234B, 1'b1, 1'b0);
            wait_idle();
        end

        // R8: chaining in-band keeps cs low across three words
        cfg_len = 2'd0; cfg_half = 8'd1; cfg_cpol = 1'b1; cfg_cpha = 1'b1;
        r0 = cs_rises;
        send(24'h000011, 1'b0, 1'b0);
        send(24'h000022, 1'b0, 1'b0);
        send(24'h000033, 1'b1, 1'b0);
        wait_idle();
        chk("R8 in-band chain cs rises", cs_rises - r0, 32'd1);

        // R8/R5: separate pin, tag change forces a cs bounce
        cfg_sep_a0 = 1'b1; cfg_cpha = 1'b0;
        r0 = cs_rises;
        send(24'h000044, 1'b0, 1'b0);
        send(24'h000055, 1'b0, 1'b0);
        send(24'h000066, 1'b1, 1'b0);
        wait_idle();
        chk("R8 separate-pin tag change cs rises", cs_rises - r0, 32'd2);

        chk("R2 all expected frames seen", q.size(), 32'd0);
        finish_run();
    end
endmodule